// File: doc/BRIEF.md
# Ticket-Ordered Lock Arbiter

This block arbitrates one shared lock among N requesters and grants it strictly in order of arrival. It keeps two shared counters: the next ticket to hand out and the ticket now being served. When a requester with no ticket pulses its acquire input, it is given the current next-ticket value in one atomic step, and that counter advances. The requester owns the lock while its stored ticket equals the serving counter. When it pulses release, the serving counter steps by one and the lock passes to the next ticket holder.

Each requester also has a wait distance output: how many tickets are ahead of its own. A client can use this to scale its back-off delay before it looks at its grant again. Both counters wrap modulo 2^W. Because W is at least log2(N)+1, modular subtraction yields the true distance. Several acquires in one cycle are served in ascending index order. A release from a requester that does not own the lock changes nothing and raises a one-cycle error pulse.

Top module: `ticket_lock`

## Requirements
- R1: During and straight after reset both counters are 0, and tkt_vld, granted, bad_release and every wait_dist slice are 0.
- R2: An acquire pulse from requester i that holds no ticket makes tkt_vld[i] pulse high for exactly the next cycle. From that cycle on, ticket slice i holds the next-ticket value from before the increment, and the counter has advanced by one.
- R3: Acquires accepted in the same cycle get consecutive tickets, with the smallest index receiving the smallest ticket, and the next-ticket counter advances by the number accepted.
- R4: An acquire from a requester that already holds a ticket is ignored: no tkt_vld pulse follows, and its ticket and its place in line are unchanged.
- R5: granted[i] is registered. It rises one cycle after requester i's stored ticket first equals the serving counter, so an acquire into an idle lock gives tkt_vld in the first cycle and granted in the second.
- R6: At most one granted bit is high in any cycle.
- R7: A release pulse from the owner advances the serving counter by one, drops its granted bit in the next cycle, and the next ticket holder's granted rises one cycle after that (strict FIFO order).
- R8: A release pulse from a requester that does not own the lock leaves the counters, tickets and grants unchanged, and bad_release is high for exactly the next cycle.
- R9: wait_dist slice i equals (ticket_i − serving) mod 2^W while requester i holds a ticket, and is 0 otherwise. The owner therefore reads 0.
- R10: Both counters wrap modulo 2^W (ticket 2^W−1 is followed by ticket 0), and FIFO service and wait distances stay correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq | input | N | Per-requester acquire pulse |
| rel | input | N | Per-requester release pulse |
| tkt_vld | output | N | One-cycle pulse: ticket slice i was just loaded |
| tkt | output | N*W | Stored ticket per requester; slice i is bits [i*W +: W] |
| granted | output | N | Registered ownership indication per requester |
| wait_dist | output | N*W | Tickets ahead of requester i; slice i is bits [i*W +: W] |
| bad_release | output | 1 | One-cycle pulse after a release from a non-owner |

## Verification
The core handoff is driven in three patterns, and each separates different faults.

- **Lone acquire into an idle lock.** This fixes the cycle in which the ticket appears and the cycle in which the grant appears.
- **Two and then three simultaneous acquires.** These show whether tickets go out in ascending index order, and whether the counter advances by the count or only by one.
- **Chains of releases with stray releases and repeat acquires mixed in.** These tell a true owner handoff apart from a wrongly accepted release or acquire.

A long run of single acquire/release rounds carries the counters past 2^W−1. This exposes comparison or distance logic that is not modular.

// File: rtl/ticket_lock.sv
module ticket_lock #(
  parameter int N = 4,
  parameter int W = $clog2(N) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   acq,
  input  logic [N-1:0]   rel,
  output logic [N-1:0]   tkt_vld,
  output logic [N*W-1:0] tkt,
  output logic [N-1:0]   granted,
  output logic [N*W-1:0] wait_dist,
  output logic           bad_release
);

  logic [W-1:0] next_q, serve_q, next_d;
  logic [W-1:0] tkt_q [N];
  logic [W-1:0] offer [N];
  logic [N-1:0] busy_q, vld_q, gnt_q;
  logic [N-1:0] take, holder, rel_ok;
  logic         rel_bad, bad_q;

  always_comb begin
    logic [W-1:0] run;
    run = '0;
    for (int i = 0; i < N; i++) begin
      take[i]   = acq[i] & ~busy_q[i];
      holder[i] = busy_q[i] && (tkt_q[i] == serve_q);
      offer[i]  = next_q + run;
      run       = run + W'(take[i]);
    end
    next_d = next_q + run;
  end

  assign rel_ok  = rel & holder;
  assign rel_bad = |(rel & ~holder);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q  <= '0;
      serve_q <= '0;
      busy_q  <= '0;
      vld_q   <= '0;
      gnt_q   <= '0;
      bad_q   <= 1'b0;
      for (int i = 0; i < N; i++) tkt_q[i] <= '0;
    end else begin
      next_q <= next_d;
      if (|rel_ok) serve_q <= serve_q + W'(1);
      vld_q <= take;
      gnt_q <= holder & ~rel_ok;
      bad_q <= rel_bad;
      for (int i = 0; i < N; i++) begin
        if (take[i]) begin
          busy_q[i] <= 1'b1;
          tkt_q[i]  <= offer[i];
        end else if (rel_ok[i]) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end

  assign tkt_vld     = vld_q;
  assign granted     = gnt_q;
  assign bad_release = bad_q;

  for (genvar g = 0; g < N; g++) begin : g_req
    assign tkt[g*W +: W]       = tkt_q[g];
    assign wait_dist[g*W +: W] = busy_q[g] ? (tkt_q[g] - serve_q) : '0;

    assert_grant_has_ticket_R5: assert property (@(posedge clk) disable iff (!rst_n)
      granted[g] |-> busy_q[g]);

    assert_repeat_acq_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (acq[g] && busy_q[g]) |=> (!tkt_vld[g] && $stable(tkt_q[g])));

    assert_dist_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q[g] |-> (int'(wait_dist[g*W +: W]) < N));
  end

  assert_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(granted));

  assert_serve_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_ok) |=> (serve_q == $past(serve_q) + W'(1)));

  assert_serve_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|rel_ok) |=> $stable(serve_q));

  assert_stray_flagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_bad |=> bad_release);

endmodule

// File: tb/ticket_lock_bench.sv
module ticket_lock_bench;
  localparam int N = 4;
  localparam int W = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   acq = '0, rel = '0;
  logic [N-1:0]   tkt_vld, granted;
  logic [N*W-1:0] tkt, wait_dist;
  logic           bad_release;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  ticket_lock #(.N(N), .W(W)) u_ticket_lock (
    .clk(clk), .rst_n(rst_n), .acq(acq), .rel(rel), .tkt_vld(tkt_vld),
    .tkt(tkt), .granted(granted), .wait_dist(wait_dist), .bad_release(bad_release)
  );

  always #5 clk = ~clk;

  // {acq, rel, expected tkt_vld, expected granted, expected bad_release}
  localparam int STEPS = 11;
  localparam logic [16:0] TBL [STEPS] = '{
    {4'b0001, 4'b0000, 4'b0001, 4'b0000, 1'b0},
    {4'b0110, 4'b0000, 4'b0110, 4'b0001, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0},
    {4'b0000, 4'b0010, 4'b0000, 4'b0001, 1'b1},
    {4'b0000, 4'b0001, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0010, 1'b0},
    {4'b0001, 4'b0010, 4'b0001, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0100, 1'b0},
    {4'b0100, 4'b0000, 4'b0000, 4'b0100, 1'b0},
    {4'b0000, 4'b0100, 4'b0000, 4'b0000, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0001, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int tk(input int i);
    return int'(tkt[i*W +: W]);
  endfunction

  function automatic int wd(input int i);
    return int'(wait_dist[i*W +: W]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nxt;
    int srv;
    repeat (3) @(negedge clk);
    check("R1 granted in reset", int'(granted), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tkt_vld after reset", int'(tkt_vld), 0);
    check("R1 bad_release after reset", int'(bad_release), 0);
    check("R1 wait_dist after reset", int'(wait_dist), 0);
    check("R1 granted after reset", int'(granted), 0);

    // Table walk: R2 R3 R4 R5 R7 R8
    for (int s = 0; s < STEPS; s++) begin
      acq = TBL[s][16:13];
      rel = TBL[s][12:9];
      step();
      acq = '0;
      rel = '0;
      check($sformatf("R2/R4 tkt_vld step %0d", s), int'(tkt_vld), int'(TBL[s][8:5]));
      check($sformatf("R5/R7 granted step %0d", s), int'(granted), int'(TBL[s][4:1]));
      check($sformatf("R8 bad_release step %0d", s), int'(bad_release), int'(TBL[s][0]));
      check($sformatf("R6 one owner step %0d", s), $countones(granted) <= 1, 1);
    end
    // After the table: next=4, serving=3, requester 0 owns ticket 3
    check("R2 ticket of requester 0", tk(0), 3);
    check("R9 owner distance", wd(0), 0);
    check("R9 idle distance", wd(1), 0);

    // R3: three same-cycle acquires get 4, 5, 6 in index order
    acq = 4'b1110;
    step();
    acq = '0;
    check("R3 ticket r1", tk(1), 4);
    check("R3 ticket r2", tk(2), 5);
    check("R3 ticket r3", tk(3), 6);
    check("R9 distance r1", wd(1), 1);
    check("R9 distance r2", wd(2), 2);
    check("R9 distance r3", wd(3), 3);

    // R7: FIFO handoff chain 0 -> 1 -> 2 -> 3
    for (int r = 0; r < N; r++) begin
      rel = 4'(1 << r);
      step();
      rel = '0;
      check("R7 owner drops", int'(granted[r]), 0);
      if (r < N - 1) begin
        check("R9 next waiter distance", wd(r + 1), 0);
        step();
        check("R7 next owner granted", int'(granted), 1 << (r + 1));
      end
    end
    nxt = 7;
    srv = 7;

    // R10: single rounds carry both counters across the wrap
    for (int k = 0; k < 6; k++) begin
      acq = 4'b0100;
      step();
      acq = '0;
      check("R10 tkt_vld", int'(tkt_vld), 4'b0100);
      check("R10 ticket value", tk(2), nxt);
      check("R10 distance", wd(2), (nxt - srv) & 7);
      check("R5 not granted yet", int'(granted), 0);
      nxt = (nxt + 1) & 7;
      step();
      check("R10 granted after wrap", int'(granted), 4'b0100);
      rel = 4'b0100;
      step();
      rel = '0;
      srv = (srv + 1) & 7;
      check("R10 release", int'(granted), 0);
    end

    // R10 distance across the wrap: serving=5, tickets 5, 6, 7, 0
    acq = 4'b1111;
    step();
    acq = '0;
    check("R10 wrap ticket r3", tk(3), 0);
    check("R10 wrap distance r3", wd(3), 3);
    check("R10 wrap distance r0", wd(0), 0);

    // R8: a stray release leaves the owner and the line intact
    step();
    rel = 4'b1000;
    step();
    rel = '0;
    check("R8 stray flagged", int'(bad_release), 1);
    check("R8 owner kept", int'(granted), 4'b0001);
    check("R8 distance kept", wd(3), 3);
    step();
    check("R8 flag one cycle", int'(bad_release), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule